// File: doc/BRIEF.md
# Transmit Sample FIFO with Threshold Interrupts

This block buffers outgoing audio samples between a register write port and a serial output stage. Software or a DMA engine writes 32-bit words into a data register. The serializer takes them in order over a ready/valid handshake, but only while transfer is enabled. The FIFO holds 32 words. Its fill level can be read back at any time.

Two conditions drive the interrupt line. The first is level-triggered: it holds while the fill level is at or below a programmable low-water mark. The second is a sticky underrun flag: it is set when the serializer asks for a sample and none is available. A DMA request output follows its own low-water mark. A write-one flush command empties the buffer. The flush reports busy for a fixed number of cycles and then clears itself.

Register map (2-bit word address): 0 = control (read/write), 1 = data (write pushes, reads 0), 2 = status (read; writes act as commands), 3 = reads 0.

Top module: `txfifo_irq`

## Requirements
- R1: After reset the control register reads 0x0000_0100, which means every enable is 0, the empty threshold is 16 and the DMA level is 0. After reset the status register reads 0, and sampleValid, txIrq and dmaReq are all 0.
- R2: Each write to address 1 stores one word. The level field (status bits [5:0]) counts the stored words, from 0 to 32. When transfer is enabled (control bit 0), the words leave on sampleData in the order they were written. One word leaves for each cycle in which sampleValid and sampleReady are both 1. While transfer is disabled, or while the FIFO is empty, sampleValid stays 0.
- R3: A data write that arrives while the level is 32 is discarded. The level stays at 32, the discarded word is never delivered, and the overflow flag (status bit 10) is set.
- R4: Status bit 8, and through it txIrq, is 1 exactly when the empty-interrupt enable (control bit 1) is 1 and the level is at or below the empty threshold (control bits [8:4]).
- R5: The underrun flag (status bit 9) is set when sampleReady is 1, transfer is enabled, the FIFO is empty and no flush is running. It stays set until status bit 9 is written with 1. When the underrun enable (control bit 2) is 1, the flag drives txIrq. While transfer is disabled, requests from the serializer never set the flag.
- R6: Writing 1 to status bit 11 empties the FIFO at the next edge. Status bit 11 then reads 1 for FLUSH_CYCLES cycles (2 by default) and returns to 0 by itself. Data writes made while the flush is running are discarded. The flush leaves the control register unchanged.
- R7: dmaReq is 1 exactly when the DMA enable (control bit 3) is 1 and the level is at or below the DMA level (control bits [16:12]).
- R8: Writing 1 to status bit 10 clears the overflow flag. Writing 0 to the flag bits leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| sampleData | output | 32 | Oldest stored word |
| sampleValid | output | 1 | A word is offered to the serializer |
| sampleReady | input | 1 | The serializer takes or requests a word |
| txIrq | output | 1 | Combined interrupt line |
| dmaReq | output | 1 | DMA refill request |

## Verification
The bench fills the FIFO to exactly 32 entries and then writes one word more. A design that accepted that write would overwrite the oldest entry or wrap the level to 0, and the scoreboard would see a word out of order or an extra word. Both low-water marks are tested right at the boundary: a level equal to the threshold must still assert, and one word more must deassert, so an off-by-one comparison fails. The flush test writes a data word on the cycle after the flush command. A design that accepted that word would leave the level at 1. The same test counts the busy cycles and reads the control register back afterward. The underrun test shows that the flag survives idle cycles, and that serializer requests made while transfer is disabled cannot set it.

// File: rtl/txfifo_irq_pkg.sv
package txfifo_irq_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_RSVD = 2'd3
  } regAddr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } fifoStrb_t;

  localparam int CTRL_XFER     = 0;
  localparam int CTRL_EIE      = 1;
  localparam int CTRL_UIE      = 2;
  localparam int CTRL_DMA      = 3;
  localparam int CTRL_THR_LSB  = 4;
  localparam int CTRL_DLVL_LSB = 12;

  localparam int STAT_EMPTY = 8;
  localparam int STAT_UNDER = 9;
  localparam int STAT_OVER  = 10;
  localparam int STAT_FLUSH = 11;

endpackage

// File: rtl/txfifo_irq_dpath.sv
module txfifo_irq_dpath
  import txfifo_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrb_t        strb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [LVL_W-1:0] level
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push && !strb.flush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= rdPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/txfifo_irq_ctrl.sv
module txfifo_irq_ctrl
  import txfifo_irq_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int FLUSH_CYCLES = 2,
  parameter int THR_RESET    = DEPTH / 2,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1,
  localparam int THR_W = PTR_W,
  localparam int CNT_W = $clog2(FLUSH_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic [LVL_W-1:0] level,
  input  logic             sampleReady,
  output logic             sampleValid,
  output fifoStrb_t        strb,
  output logic             txIrq,
  output logic             dmaReq
);

  logic             xferEn, emptyIe, underIe, dmaEn;
  logic [THR_W-1:0] emptyThr, dmaLvl;
  logic             underFlag, overFlag;
  logic [CNT_W-1:0] flushCnt;
  logic             busy, full, empty;
  logic             ctrlWr, dataWr, statWr;
  logic             underHit, overHit, emptyStat;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata;

  assign ctrlWr = regWr && (regAddr == ADDR_CTRL);
  assign dataWr = regWr && (regAddr == ADDR_DATA);
  assign statWr = regWr && (regAddr == ADDR_STAT);

  assign busy  = (flushCnt != '0);
  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

  assign sampleValid = xferEn && !empty && !busy;
  assign underHit    = sampleReady && xferEn && empty && !busy;
  assign overHit     = dataWr && !busy && full;
  assign emptyStat   = emptyIe && (level <= {1'b0, emptyThr});

  always_comb begin
    strb.push  = dataWr && !busy && !full;
    strb.pop   = sampleValid && sampleReady;
    strb.flush = statWr && regWdata[STAT_FLUSH];
  end

  assign txIrq  = emptyStat || (underIe && underFlag);
  assign dmaReq = dmaEn && (level <= {1'b0, dmaLvl});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferEn    <= 1'b0;
      emptyIe   <= 1'b0;
      underIe   <= 1'b0;
      dmaEn     <= 1'b0;
      emptyThr  <= THR_W'(THR_RESET);
      dmaLvl    <= '0;
      underFlag <= 1'b0;
      overFlag  <= 1'b0;
      flushCnt  <= '0;
    end else begin
      if (ctrlWr) begin
        xferEn   <= regWdata[CTRL_XFER];
        emptyIe  <= regWdata[CTRL_EIE];
        underIe  <= regWdata[CTRL_UIE];
        dmaEn    <= regWdata[CTRL_DMA];
        emptyThr <= regWdata[CTRL_THR_LSB +: THR_W];
        dmaLvl   <= regWdata[CTRL_DLVL_LSB +: THR_W];
      end
      if (underHit)                             underFlag <= 1'b1;
      else if (statWr && regWdata[STAT_UNDER]) underFlag <= 1'b0;
      if (overHit)                              overFlag <= 1'b1;
      else if (statWr && regWdata[STAT_OVER])  overFlag <= 1'b0;
      if (strb.flush)  flushCnt <= CNT_W'(FLUSH_CYCLES);
      else if (busy)   flushCnt <= flushCnt - 1'b1;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[CTRL_XFER]                = xferEn;
        regRdata[CTRL_EIE]                 = emptyIe;
        regRdata[CTRL_UIE]                 = underIe;
        regRdata[CTRL_DMA]                 = dmaEn;
        regRdata[CTRL_THR_LSB +: THR_W]    = emptyThr;
        regRdata[CTRL_DLVL_LSB +: THR_W]   = dmaLvl;
      end
      ADDR_STAT: begin
        regRdata[LVL_W-1:0] = level;
        regRdata[STAT_EMPTY] = emptyStat;
        regRdata[STAT_UNDER] = underFlag;
        regRdata[STAT_OVER]  = overFlag;
        regRdata[STAT_FLUSH] = busy;
      end
      default: regRdata = '0;
    endcase
  end

endmodule

// File: rtl/txfifo_irq.sv
module txfifo_irq
  import txfifo_irq_pkg::*;
#(
  parameter int DEPTH        = 32,
  parameter int WIDTH        = 32,
  parameter int FLUSH_CYCLES = 2,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic [WIDTH-1:0] sampleData,
  output logic             sampleValid,
  input  logic             sampleReady,
  output logic             txIrq,
  output logic             dmaReq
);

  fifoStrb_t        strb;
  logic [LVL_W-1:0] level;

  txfifo_irq_ctrl #(
    .DEPTH(DEPTH),
    .FLUSH_CYCLES(FLUSH_CYCLES)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .regWr(regWr),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .level(level),
    .sampleReady(sampleReady),
    .sampleValid(sampleValid),
    .strb(strb),
    .txIrq(txIrq),
    .dmaReq(dmaReq)
  );

  txfifo_irq_dpath #(
    .DEPTH(DEPTH),
    .WIDTH(WIDTH)
  ) uDpath (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .wrData(regWdata[WIDTH-1:0]),
    .rdData(sampleData),
    .level(level)
  );

endmodule

// File: rtl/txfifo_irq_chk.sv
module txfifo_irq_chk
  import txfifo_irq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWr,
  input logic [1:0]       regAddr,
  input logic [LVL_W-1:0] level,
  input fifoStrb_t        strb,
  input logic             sampleValid,
  input logic             sampleReady,
  input logic [WIDTH-1:0] sampleData,
  input logic             dmaReq
);

  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  p_no_valid_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !sampleValid);

  p_pop_decrements_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push && !strb.flush) |=> (level == LVL_W'($past(level) - 1'b1)));

  p_head_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !sampleReady && !strb.flush) |=> $stable(sampleData));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_DATA && level == LVL_W'(DEPTH)) |-> !strb.push);

  p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (level == '0));

  p_dma_not_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (level != LVL_W'(DEPTH)));

endmodule

bind txfifo_irq txfifo_irq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) uChk (
  .clk(clk),
  .rstN(rstN),
  .regWr(regWr),
  .regAddr(regAddr),
  .level(level),
  .strb(strb),
  .sampleValid(sampleValid),
  .sampleReady(sampleReady),
  .sampleData(sampleData),
  .dmaReq(dmaReq)
);

// File: tb/txfifo_irq_test.sv
`timescale 1ns/1ps
module txfifo_irq_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWr;
  logic [1:0]  regAddr;
  logic [31:0] regWdata;
  logic [31:0] regRdata;
  logic [31:0] sampleData;
  logic        sampleValid;
  logic        sampleReady;
  logic        txIrq;
  logic        dmaReq;

  int nChecks = 0;
  int nFail   = 0;
  logic [31:0] expQ[$];

  always #2 clk = ~clk;

  txfifo_irq uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .txIrq(txIrq), .dmaReq(dmaReq)
  );

  task automatic chkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wrReg(logic [1:0] a, logic [31:0] d);
    regWr = 1'b1; regAddr = a; regWdata = d;
    tick();
    regWr = 1'b0; regWdata = '0;
  endtask

  task automatic rdReg(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    @(negedge clk);
    d = regRdata;
    tick();
  endtask

  // driver: word expected to be accepted goes to the scoreboard
  task automatic pushSample(logic [31:0] d);
    expQ.push_back(d);
    wrReg(2'd1, d);
  endtask

  function automatic logic [31:0] ctrlWord(bit x, bit e, bit u, bit d, int thr, int dl);
    return {15'd0, 5'(dl), 3'd0, 5'(thr), d, u, e, x};
  endfunction

  task automatic drain();
    sampleReady = 1'b1;
    for (int i = 0; i < 100 && sampleValid; i++) tick();
    tick();
    sampleReady = 1'b0;
  endtask

  // monitor: compare each delivered word with the scoreboard
  always @(negedge clk) begin
    if (rstN === 1'b1 && sampleValid && sampleReady) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R2 unexpected word: actual=%h expected=none", sampleData);
      end else begin
        chkEq("R2 delivery order", sampleData, expQ.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    regWr = 0; regAddr = 0; regWdata = 0; sampleReady = 0; rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    chkEq("R1 sampleValid", 32'(sampleValid), 0);
    chkEq("R1 txIrq", 32'(txIrq), 0);
    chkEq("R1 dmaReq", 32'(dmaReq), 0);
    rdReg(2'd0, r); chkEq("R1 control reset", r, 32'h100);
    rdReg(2'd2, r); chkEq("R1 status reset", r, 0);

    // R2 ordered delivery, held while disabled
    for (int i = 0; i < 5; i++) pushSample(32'hA000_0000 + i);
    rdReg(2'd2, r); chkEq("R2 level after 5", 32'(r[5:0]), 5);
    chkEq("R2 no valid while disabled", 32'(sampleValid), 0);
    sampleReady = 1'b1;
    wrReg(2'd0, ctrlWord(1, 0, 0, 0, 16, 0));
    drain();
    chkEq("R2 scoreboard empty", 32'(expQ.size()), 0);
    rdReg(2'd2, r); chkEq("R2 level drained", 32'(r[5:0]), 0);

    // R2 with gaps in ready
    for (int i = 0; i < 8; i++) pushSample(32'h5A5A_0000 + i * 3);
    for (int i = 0; i < 40; i++) begin
      sampleReady = i[0];
      tick();
    end
    sampleReady = 1'b0;
    chkEq("R2 gapped scoreboard empty", 32'(expQ.size()), 0);

    // R3 full and dropped write
    for (int i = 0; i < 32; i++) pushSample(32'hB000_0000 + i);
    rdReg(2'd2, r); chkEq("R3 level full", 32'(r[5:0]), 32);
    wrReg(2'd1, 32'hDEAD_BEEF);
    rdReg(2'd2, r);
    chkEq("R3 level stays 32", 32'(r[5:0]), 32);
    chkEq("R3 overflow set", 32'(r[10]), 1);
    // R8 write-one clear
    wrReg(2'd2, 32'h0);
    rdReg(2'd2, r); chkEq("R8 zero write keeps overflow", 32'(r[10]), 1);
    wrReg(2'd2, 32'h400);
    rdReg(2'd2, r); chkEq("R8 overflow cleared", 32'(r[10]), 0);
    drain();
    chkEq("R3 all 32 delivered, dropped word absent", 32'(expQ.size()), 0);
    wrReg(2'd2, 32'h200);

    // R4 empty threshold
    wrReg(2'd0, ctrlWord(1, 1, 0, 0, 16, 0));
    chkEq("R4 irq at level 0", 32'(txIrq), 1);
    for (int i = 0; i < 16; i++) pushSample(32'hC000_0000 + i);
    chkEq("R4 irq at level 16 = threshold", 32'(txIrq), 1);
    rdReg(2'd2, r); chkEq("R4 status bit at threshold", 32'(r[8]), 1);
    pushSample(32'hC000_0010);
    chkEq("R4 irq off at 17", 32'(txIrq), 0);
    rdReg(2'd2, r); chkEq("R4 status bit off", 32'(r[8]), 0);
    wrReg(2'd0, ctrlWord(1, 1, 0, 0, 17, 0));
    chkEq("R4 irq with threshold 17", 32'(txIrq), 1);
    wrReg(2'd0, ctrlWord(1, 0, 0, 0, 17, 0));
    chkEq("R4 irq masked", 32'(txIrq), 0);

    // R6 flush
    wrReg(2'd0, ctrlWord(1, 0, 0, 1, 20, 7));
    chkEq("R7 no dma at level 17", 32'(dmaReq), 0);
    expQ.delete();
    wrReg(2'd2, 32'h800);
    wrReg(2'd1, 32'h00C0_FFEE);
    rdReg(2'd2, r);
    chkEq("R6 busy second cycle", 32'(r[11]), 1);
    chkEq("R6 level zero, write during flush dropped", 32'(r[5:0]), 0);
    rdReg(2'd2, r); chkEq("R6 busy self-cleared", 32'(r[11]), 0);
    rdReg(2'd0, r); chkEq("R6 control unchanged", r, ctrlWord(1, 0, 0, 1, 20, 7));

    // R7 DMA request
    chkEq("R7 dma at level 0", 32'(dmaReq), 1);
    for (int i = 0; i < 7; i++) pushSample(32'hD000_0000 + i);
    chkEq("R7 dma at level 7 = dma level", 32'(dmaReq), 1);
    pushSample(32'hD000_0007);
    chkEq("R7 dma off at 8", 32'(dmaReq), 0);
    wrReg(2'd0, ctrlWord(1, 0, 0, 0, 20, 31));
    chkEq("R7 dma disabled", 32'(dmaReq), 0);
    drain();
    chkEq("R6 post-flush scoreboard empty", 32'(expQ.size()), 0);

    // R5 underrun
    wrReg(2'd2, 32'h200);
    wrReg(2'd0, ctrlWord(0, 0, 1, 0, 16, 0));
    sampleReady = 1'b1;
    repeat (3) tick();
    sampleReady = 1'b0;
    rdReg(2'd2, r); chkEq("R5 no underrun while disabled", 32'(r[9]), 0);
    chkEq("R5 no irq while disabled", 32'(txIrq), 0);
    wrReg(2'd0, ctrlWord(1, 0, 1, 0, 16, 0));
    sampleReady = 1'b1;
    tick();
    sampleReady = 1'b0;
    chkEq("R5 irq on underrun", 32'(txIrq), 1);
    repeat (5) tick();
    rdReg(2'd2, r); chkEq("R5 underrun sticky", 32'(r[9]), 1);
    wrReg(2'd2, 32'h200);
    chkEq("R5 irq cleared", 32'(txIrq), 0);
    rdReg(2'd2, r); chkEq("R5 underrun cleared", 32'(r[9]), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule